// File: doc/BRIEF.md
# Link Packet Framer

This block turns a transaction-level packet into a framed byte stream for a serial link. The layer above presents the packet one dword at a time on a valid/ready interface: the header (3 dwords, or 4 for 64-bit addressing) followed by 0 to 1024 payload dwords. It flags the final dword with `in_last`. With that final dword it also supplies a digest flag and an end-to-end CRC value. If the digest flag is set, the framer inserts the end-to-end CRC as one more dword behind the payload.

The framer wraps the packet for the link. In front it places a start symbol and a two-byte sequence field, which carries a 12-bit packet counter. Behind it places a 32-bit link CRC and an end symbol. Bytes leave one per accepted cycle on a second valid/ready interface. A control flag beside each byte marks the two framing symbols. Line coding, scrambling, lane striping and replay storage belong to later stages and are not part of this block.

Top module: `link_pkt_framer`

## Requirements
- R1: Each packet leaves in this order: start symbol, two sequence bytes, every input dword, the end-to-end CRC dword when requested, four link CRC bytes, end symbol. No byte of a packet is lost and none is added.
- R2: The start symbol is 0xFB and the end symbol is 0xFD, and both leave with `out_ctrl` high. Every other byte leaves with `out_ctrl` low.
- R3: The first sequence byte is {4'h0, count[11:8]} and the second is count[7:0]. The count is 0 for the first packet after reset and rises by one per packet. After 4095 it wraps to 0.
- R4: Every 32-bit word is sent most significant byte first, bits [31:24] leading. This covers input dwords, the end-to-end CRC and the link CRC.
- R5: The value of `in_digest` on the `in_last` transfer decides whether `in_ecrc`, as sampled on that transfer, is inserted after the last input dword. On any other transfer, `in_digest` and `in_ecrc` have no effect.
- R6: The link CRC is CRC-32 with polynomial 0x04C11DB7 and seed 0xFFFFFFFF. It takes each byte most significant bit first. It covers the two sequence bytes, all input dwords and, when present, the end-to-end CRC. The CRC is inverted bitwise before it is sent.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_byte` and `out_ctrl` hold their values into the next cycle.
- R8: `in_ready` is high only in a cycle in which the fourth byte of the current input dword is being accepted downstream. One dword is consumed per four output bytes.
- R9: During reset, and whenever no packet is offered between packets, `out_valid` and `in_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input dword valid |
| in_ready | output | 1 | Input dword consumed this cycle |
| in_data | input | 32 | Header or payload dword |
| in_last | input | 1 | Marks the final dword of the packet |
| in_digest | input | 1 | Request end-to-end CRC insertion (sampled with in_last) |
| in_ecrc | input | 32 | End-to-end CRC value (sampled with in_last) |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the byte |
| out_byte | output | 8 | Output byte |
| out_ctrl | output | 1 | Byte is a framing symbol |

## Verification
The assertions check four properties on every cycle. A stalled byte stays unchanged. The control flag appears only on the two symbol codes. The byte after a start symbol is data. Input is taken only while a byte is accepted downstream. The content of each packet can only be shown by the bench's scenarios, checked against a byte-level model. That content covers the sequence count through a full wrap, the link CRC, byte order, and inserting or omitting the digest. The scenarios use packet lengths from an empty payload to 1024 dwords, with random gaps on the input and random stalls on the output.

// File: rtl/link_pkt_framer.sv
module link_pkt_framer #(
  parameter logic [7:0] START_SYM = 8'hFB,
  parameter logic [7:0] END_SYM   = 8'hFD,
  parameter int         SEQ_W     = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  input  logic        in_last,
  input  logic        in_digest,
  input  logic [31:0] in_ecrc,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_byte,
  output logic        out_ctrl
);
  localparam logic [31:0] POLY = 32'h04C11DB7;

  typedef enum logic [2:0] {S_STP, S_SEQH, S_SEQL, S_BODY, S_ECRC, S_LCRC, S_END} st_t;

  st_t              st;
  logic [1:0]       idx;
  logic [SEQ_W-1:0] seq;
  logic [31:0]      crc, ecrc_q;
  logic [15:0]      seq_field;
  logic             fire;

  function automatic logic [7:0] pick(input logic [31:0] w, input logic [1:0] i);
    case (i)
      2'd0:    return w[31:24];
      2'd1:    return w[23:16];
      2'd2:    return w[15:8];
      default: return w[7:0];
    endcase
  endfunction

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int k = 7; k >= 0; k--) begin
      if (r[31] ^ b[k]) r = {r[30:0], 1'b0} ^ POLY;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction

  assign seq_field = 16'(seq);
  assign out_valid = (st == S_STP || st == S_BODY) ? in_valid : 1'b1;
  assign out_ctrl  = (st == S_STP || st == S_END);
  assign fire      = out_valid && out_ready;
  assign in_ready  = (st == S_BODY) && (idx == 2'd3) && out_ready;

  always_comb begin
    case (st)
      S_STP:   out_byte = START_SYM;
      S_SEQH:  out_byte = seq_field[15:8];
      S_SEQL:  out_byte = seq_field[7:0];
      S_BODY:  out_byte = pick(in_data, idx);
      S_ECRC:  out_byte = pick(ecrc_q, idx);
      S_LCRC:  out_byte = pick(~crc, idx);
      default: out_byte = END_SYM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_STP;
      idx    <= '0;
      seq    <= '0;
      crc    <= '1;
      ecrc_q <= '0;
    end else if (fire) begin
      case (st)
        S_STP: begin
          crc <= '1;
          st  <= S_SEQH;
        end
        S_SEQH: begin
          crc <= crc_step(crc, out_byte);
          st  <= S_SEQL;
        end
        S_SEQL: begin
          crc <= crc_step(crc, out_byte);
          idx <= '0;
          st  <= S_BODY;
        end
        S_BODY: begin
          crc <= crc_step(crc, out_byte);
          idx <= idx + 2'd1;
          if (idx == 2'd3 && in_last) begin
            ecrc_q <= in_ecrc;
            st     <= in_digest ? S_ECRC : S_LCRC;
          end
        end
        S_ECRC: begin
          crc <= crc_step(crc, out_byte);
          idx <= idx + 2'd1;
          if (idx == 2'd3) st <= S_LCRC;
        end
        S_LCRC: begin
          idx <= idx + 2'd1;
          if (idx == 2'd3) st <= S_END;
        end
        default: begin
          seq <= seq + 1'b1;
          st  <= S_STP;
        end
      endcase
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(out_ctrl));

  assert_ctrl_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ctrl |-> (out_byte == START_SYM || out_byte == END_SYM));

  assert_data_after_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fire && out_ctrl && out_byte == START_SYM |=> out_valid && !out_ctrl);

  assert_take_with_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> out_ready && out_valid == in_valid && !out_ctrl);

endmodule

// File: tb/tb_link_pkt_framer.sv
module tb_link_pkt_framer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready, in_last = 1'b0, in_digest = 1'b0;
  logic [31:0] in_data = '0, in_ecrc = '0;
  logic        out_valid, out_ready = 1'b0, out_ctrl;
  logic [7:0]  out_byte;

  int vectors = 0, errors = 0, cycles = 0, mseq = 0;
  bit stall_en = 0, gap_en = 0;
  logic [8:0] exp_q[$];
  string      tag_q[$];

  link_pkt_framer dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .in_digest(in_digest), .in_ecrc(in_ecrc),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte), .out_ctrl(out_ctrl)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  function automatic logic [31:0] ref_lcrc(input logic [7:0] m[$]);
    logic [31:0] r;
    logic        top;
    r = 32'hFFFF_FFFF;
    foreach (m[k]) begin
      for (int b = 7; b >= 0; b--) begin
        top = r[31] ^ m[k][b];
        r = r << 1;
        if (top) r = r ^ 32'h04C11DB7;
      end
    end
    return ~r;
  endfunction

  task automatic push(input logic ctrl, input logic [7:0] b, input string tag);
    exp_q.push_back({ctrl, b});
    tag_q.push_back(tag);
  endtask

  task automatic send_pkt(input int hdr_dw, input int pl_dw, input bit dig);
    logic [31:0] words[$];
    logic [7:0]  crcmsg[$];
    logic [31:0] ecrc, lc;
    int          n;
    for (int i = 0; i < hdr_dw + pl_dw; i++) words.push_back($urandom);
    ecrc = $urandom;
    n = words.size();
    push(1'b1, 8'hFB, "R2");
    crcmsg.push_back({4'h0, 4'(mseq >> 8)});
    crcmsg.push_back(8'(mseq));
    push(1'b0, crcmsg[0], "R3");
    push(1'b0, crcmsg[1], "R3");
    for (int i = 0; i < n; i++)
      for (int j = 3; j >= 0; j--) begin
        push(1'b0, words[i][8*j +: 8], "R4");
        crcmsg.push_back(words[i][8*j +: 8]);
      end
    if (dig)
      for (int j = 3; j >= 0; j--) begin
        push(1'b0, ecrc[8*j +: 8], "R5");
        crcmsg.push_back(ecrc[8*j +: 8]);
      end
    lc = ref_lcrc(crcmsg);
    for (int j = 3; j >= 0; j--) push(1'b0, lc[8*j +: 8], "R6");
    push(1'b1, 8'hFD, "R1");
    mseq = (mseq + 1) % 4096;
    for (int i = 0; i < n; i++) begin
      if (gap_en && ($urandom % 3 == 0)) begin
        in_valid = 1'b0;
        @(posedge clk); #1;
      end
      in_valid  = 1'b1;
      in_data   = words[i];
      in_last   = (i == n - 1);
      in_digest = (i == n - 1) ? dig : 1'($urandom);
      in_ecrc   = (i == n - 1) ? ecrc : $urandom;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    #1;
    out_ready = stall_en ? ($urandom % 3 != 0) : (rst_n ? 1'b1 : 1'b0);
  end

  logic       prev_stall = 1'b0;
  logic [8:0] prev_out;
  always @(negedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      summary();
    end
    if (rst_n) begin
      if (prev_stall)
        check(out_valid && {out_ctrl, out_byte} == prev_out, "R7", "stalled byte held",
              {23'd0, out_ctrl, out_byte}, {23'd0, prev_out});
      if (in_ready)
        check(out_valid && out_ready, "R8", "input taken only with output accept",
              {30'd0, out_valid, out_ready}, 32'd3);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0)
          check(1'b0, "R1", "unexpected extra byte", {23'd0, out_ctrl, out_byte}, 32'd0);
        else begin
          logic [8:0] e;
          string      t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({out_ctrl, out_byte} == e, t, "byte/ctrl", {23'd0, out_ctrl, out_byte}, {23'd0, e});
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_out   = {out_ctrl, out_byte};
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!out_valid, "R9", "out_valid in reset", {31'd0, out_valid}, 32'd0);
    check(!in_ready,  "R9", "in_ready in reset",  {31'd0, in_ready},  32'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!out_valid, "R9", "idle after reset", {31'd0, out_valid}, 32'd0);
    @(posedge clk); #1;

    send_pkt(3, 0, 0);
    send_pkt(4, 2, 1);
    send_pkt(3, 5, 1);
    drain();
    check(!out_valid, "R9", "idle between packets", {31'd0, out_valid}, 32'd0);

    stall_en = 1; gap_en = 1;
    send_pkt(4, 0, 1);
    send_pkt(3, 7, 0);
    send_pkt(4, 1024, 1);
    send_pkt(3, 1, 0);
    drain();
    stall_en = 0; gap_en = 0;
    @(posedge clk); #1;

    // R3: drive the count through its wrap point
    while (mseq != 4094) send_pkt(3, 0, 0);
    stall_en = 1;
    for (int i = 0; i < 4; i++) send_pkt(3, 1, i[0]);
    drain();
    check(exp_q.size() == 0, "R1", "all expected bytes emitted", exp_q.size(), 32'd0);
    check(!out_valid, "R9", "idle at end", {31'd0, out_valid}, 32'd0);
    summary();
  end
endmodule